// File: doc/BRIEF.md
# ModRM/SIB Effective Address Decoder

This block sits in the operand path of an instruction decoder. After a `start` pulse it takes the addressing bytes of one instruction from a byte stream with a valid/ready handshake. It takes the mode/reg/rm byte first, then an optional scale-index-base byte, then an optional little-endian displacement. It stops once the last byte that the addressing form needs has been taken. It then reports three things: the reg field; whether the second operand is a register or memory; and either the register number or the computed effective address.

Both address sizes are covered. The 32-bit forms include scaled index, the no-index code, the stream-supplied base and the address formed by a displacement alone. The 16-bit forms use the eight fixed base/index pairs, and their result wraps to 16 bits. The block also flags when the default segment for the access becomes the stack segment. That flag is forced low when a segment override is present. At `start`, the register file values, the address-size flag and the override flag are all captured, so the result stays fixed until the next `start`.

Top module: `modrm_ea_decoder`

## Requirements
- R1: The first byte splits into mode = bits 7:6, reg = bits 5:3 and rm = bits 2:0. `reg_fld` shows reg. With mode 3 the operand is a register: `is_mem` is 0, `rm_reg` shows rm, and no further byte is taken.
- R2: `in_ready` is high only while a decode still needs bytes. A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. `done` rises on the edge that takes the last needed byte. Out of reset, `done` and `in_ready` are both 0.
- R3: In 32-bit mode, rm 4 with mode 0–2 takes a second byte (scale = bits 7:6, index = bits 5:3, base = bits 2:0). The address is base register plus index register shifted left by scale. Index code 4 contributes nothing.
- R4: In 32-bit mode, when that second byte has base code 5 and mode is 0, four stream bytes form the base value in place of a register, and no other displacement follows. With mode 1 or 2, base code 5 selects register 5.
- R5: In 32-bit mode without the second byte, rm 5 with mode 0 gives an address equal to a 32-bit displacement. With mode 1 or 2, register 5 is the base.
- R6: Mode 1 adds a sign-extended 8-bit displacement. Mode 2 adds a 32-bit displacement in 32-bit mode and a 16-bit one in 16-bit mode. Displacement bytes arrive least significant first.
- R7: In 16-bit mode, rm 0..7 selects the base: reg3+reg6, reg3+reg7, reg5+reg6, reg5+reg7, reg6, reg7, reg5, reg3. Each register uses its low 16 bits. With mode 0, rm 6 instead takes a 16-bit displacement alone.
- R8: In 16-bit mode the effective address is the sum modulo 2^16, and bits 31:16 of `eff_addr` are 0.
- R9: `use_ss` is 1 under these conditions: in 16-bit mode, for rm 2 or 3, or for rm 6 with nonzero mode; in 32-bit mode, for base code 4 in the second byte, or for rm 5 with nonzero mode. It is 0 in every other case, and always 0 when the override flag was set at `start`.
- R10: After `done`, all outputs hold until the next `start`. Changes on the register inputs and stream bytes offered while `in_ready` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new decode; captures `addr32`, `seg_ovr`, `gpr_flat` |
| addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| seg_ovr | input | 1 | A segment override is present for this instruction |
| gpr_flat | input | NUM_GPR*GPR_W | Register file, register n at bits n*GPR_W+31:n*GPR_W |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| done | output | 1 | Decode complete, results valid and held |
| reg_fld | output | 3 | Reg field of the first byte |
| is_mem | output | 1 | Second operand is memory |
| rm_reg | output | 3 | Second register number (valid when `is_mem` is 0) |
| eff_addr | output | 32 | Effective address (valid when `is_mem` is 1, else 0) |
| use_ss | output | 1 | Default segment becomes the stack segment |

## Verification
Each result is due on the rising edge that takes the last needed byte. Counting from the edge that sees `start`, that edge falls at 1 + byte count + stall cycles, where the byte count ranges from 1 (register form) to 6 (second byte, 32-bit base and no further displacement), plus one stall cycle when the bench inserts a bubble. The driver computes that edge number with each expected item and queues it. The monitor counts rising edges since `start`, samples on falling edges, and requires the rise of `done` to land on exactly the predicted edge.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_MODRM,
      ST_SIB,
      ST_DISP,
      ST_DONE
   } ea_state_e;

   typedef struct packed {
      logic [1:0] mode;
      logic [2:0] reg_f;
      logic [2:0] rm;
   } modrm_t;

   typedef struct packed {
      logic [1:0] scale;
      logic [2:0] index;
      logic [2:0] base;
   } sib_t;

   localparam logic [2:0] CODE_SP = 3'd4;
   localparam logic [2:0] CODE_BP = 3'd5;
   localparam logic [2:0] CODE_16_DIRECT = 3'd6;

   // Number of displacement bytes that follow the addressing bytes.
   function automatic logic [2:0] disp_bytes(input logic       wide,
                                             input logic [1:0] mode,
                                             input logic [2:0] rm,
                                             input logic [2:0] sib_base);
      logic [2:0] n;
      unique case (mode)
         2'd1:    n = 3'd1;
         2'd2:    n = wide ? 3'd4 : 3'd2;
         2'd0: begin
            if (wide)
               n = ((rm == CODE_BP) || ((rm == CODE_SP) && (sib_base == CODE_BP))) ? 3'd4 : 3'd0;
            else
               n = (rm == CODE_16_DIRECT) ? 3'd2 : 3'd0;
         end
         default: n = 3'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/ea_fetch.sv
module ea_fetch
   import ea_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        addr32_i,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   output logic        in_ready,
   output logic        done,
   output logic        a32_q,
   output modrm_t      modrm_q,
   output sib_t        sib_q,
   output logic [31:0] disp_q,
   output logic [2:0]  len_q
);

   ea_state_e  state_q;
   logic [1:0] idx_q;
   logic       accept;
   modrm_t     m_now;
   logic [2:0] nxt_len;

   assign in_ready = (state_q == ST_MODRM) || (state_q == ST_SIB) || (state_q == ST_DISP);
   assign accept   = in_valid && in_ready;
   assign done     = (state_q == ST_DONE);

   always_comb begin
      m_now   = (state_q == ST_MODRM) ? modrm_t'(in_data) : modrm_q;
      nxt_len = disp_bytes(a32_q, m_now.mode, m_now.rm, in_data[2:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         a32_q   <= 1'b0;
         modrm_q <= '0;
         sib_q   <= '0;
         disp_q  <= '0;
         len_q   <= '0;
         idx_q   <= '0;
      end else if (start) begin
         state_q <= ST_MODRM;
         a32_q   <= addr32_i;
         modrm_q <= '0;
         sib_q   <= '0;
         disp_q  <= '0;
         len_q   <= '0;
         idx_q   <= '0;
      end else if (accept) begin
         unique case (state_q)
            ST_MODRM: begin
               modrm_q <= m_now;
               if (m_now.mode == 2'd3) begin
                  state_q <= ST_DONE;
               end else if (a32_q && (m_now.rm == CODE_SP)) begin
                  state_q <= ST_SIB;
               end else begin
                  len_q   <= nxt_len;
                  state_q <= (nxt_len == 3'd0) ? ST_DONE : ST_DISP;
               end
            end
            ST_SIB: begin
               sib_q   <= sib_t'(in_data);
               len_q   <= nxt_len;
               state_q <= (nxt_len == 3'd0) ? ST_DONE : ST_DISP;
            end
            ST_DISP: begin
               disp_q[8*idx_q +: 8] <= in_data;
               idx_q <= idx_q + 2'd1;
               if (({1'b0, idx_q} + 3'd1) == len_q)
                  state_q <= ST_DONE;
            end
            default: state_q <= state_q;
         endcase
      end
   end

   AST_REG_FORM_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_MODRM && accept && in_data[7:6] == 2'b11 && !start) |=> (state_q == ST_DONE)); // R1
   AST_SIB_NEEDS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SIB) |-> a32_q); // R3
   AST_DISP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DISP) |-> ({1'b0, idx_q} < len_q)); // R6

endmodule

// File: rtl/ea_calc.sv
module ea_calc
   import ea_pkg::*;
#(
   parameter int GPR_W   = 32,
   parameter int NUM_GPR = 8
)(
   input  logic                     wide,
   input  modrm_t                   modrm,
   input  sib_t                     sib,
   input  logic [31:0]              disp,
   input  logic [2:0]               len,
   input  logic [NUM_GPR*GPR_W-1:0] gpr_flat,
   output logic [31:0]              addr,
   output logic                     ss_cond
);

   localparam int AW = 32;

   logic [AW-1:0] r [NUM_GPR];

   for (genvar g = 0; g < NUM_GPR; g++) begin : g_unpack
      assign r[g] = gpr_flat[g*GPR_W +: AW];
   end

   logic [AW-1:0] dext;
   logic [AW-1:0] idx_val;
   logic [AW-1:0] base_val;
   logic [AW-1:0] sum32;
   logic [15:0]   base16;
   logic [15:0]   sum16;

   always_comb begin
      unique case (len)
         3'd1:    dext = {{24{disp[7]}}, disp[7:0]};
         3'd2:    dext = {{16{disp[15]}}, disp[15:0]};
         default: dext = disp;
      endcase
   end

   // Wide forms
   always_comb begin
      idx_val  = '0;
      base_val = '0;
      if (modrm.rm == CODE_SP) begin
         idx_val  = (sib.index == CODE_SP) ? '0 : (r[sib.index] << sib.scale);
         base_val = ((sib.base == CODE_BP) && (modrm.mode == 2'd0)) ? '0 : r[sib.base];
      end else if (!((modrm.rm == CODE_BP) && (modrm.mode == 2'd0))) begin
         base_val = r[modrm.rm];
      end
      sum32 = base_val + idx_val + dext;
   end

   // Narrow forms
   always_comb begin
      unique case (modrm.rm)
         3'd0: base16 = r[3][15:0] + r[6][15:0];
         3'd1: base16 = r[3][15:0] + r[7][15:0];
         3'd2: base16 = r[5][15:0] + r[6][15:0];
         3'd3: base16 = r[5][15:0] + r[7][15:0];
         3'd4: base16 = r[6][15:0];
         3'd5: base16 = r[7][15:0];
         3'd6: base16 = (modrm.mode == 2'd0) ? 16'h0000 : r[5][15:0];
         default: base16 = r[3][15:0];
      endcase
      sum16 = base16 + dext[15:0];
   end

   always_comb begin
      if (wide) begin
         addr    = sum32;
         ss_cond = (modrm.rm == CODE_SP) ? (sib.base == CODE_SP)
                                         : ((modrm.rm == CODE_BP) && (modrm.mode != 2'd0));
      end else begin
         addr    = {16'h0000, sum16};
         ss_cond = (modrm.rm == 3'd2) || (modrm.rm == 3'd3) ||
                   ((modrm.rm == CODE_16_DIRECT) && (modrm.mode != 2'd0));
      end
   end

endmodule

// File: rtl/modrm_ea_decoder.sv
module modrm_ea_decoder
   import ea_pkg::*;
#(
   parameter int GPR_W    = 32,
   parameter int NUM_GPR  = 8,
   parameter bit SNAPSHOT = 1'b1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     addr32,
   input  logic                     seg_ovr,
   input  logic [NUM_GPR*GPR_W-1:0] gpr_flat,
   input  logic                     in_valid,
   input  logic [7:0]               in_data,
   output logic                     in_ready,
   output logic                     done,
   output logic [2:0]               reg_fld,
   output logic                     is_mem,
   output logic [2:0]               rm_reg,
   output logic [31:0]              eff_addr,
   output logic                     use_ss
);

   localparam int FLAT_W = NUM_GPR * GPR_W;

   if (NUM_GPR != 8) begin : g_chk_num
      $error("modrm_ea_decoder: NUM_GPR must be 8");
   end
   if (GPR_W < 32) begin : g_chk_width
      $error("modrm_ea_decoder: GPR_W must be at least 32");
   end

   logic [FLAT_W-1:0] regs_use;
   logic              ovr_q;
   logic              a32_q;
   modrm_t            modrm_q;
   sib_t              sib_q;
   logic [31:0]       disp_q;
   logic [2:0]        len_q;
   logic [31:0]       calc_addr;
   logic              calc_ss;

   if (SNAPSHOT) begin : g_snap
      logic [FLAT_W-1:0] regs_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     regs_q <= '0;
         else if (start) regs_q <= gpr_flat;
      end
      assign regs_use = regs_q;

      AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (done && !start) |=> $stable(eff_addr)); // R10
   end else begin : g_live
      assign regs_use = gpr_flat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ovr_q <= 1'b0;
      else if (start) ovr_q <= seg_ovr;
   end

   ea_fetch u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .addr32_i (addr32),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .done     (done),
      .a32_q    (a32_q),
      .modrm_q  (modrm_q),
      .sib_q    (sib_q),
      .disp_q   (disp_q),
      .len_q    (len_q)
   );

   ea_calc #(.GPR_W(GPR_W), .NUM_GPR(NUM_GPR)) u_calc (
      .wide     (a32_q),
      .modrm    (modrm_q),
      .sib      (sib_q),
      .disp     (disp_q),
      .len      (len_q),
      .gpr_flat (regs_use),
      .addr     (calc_addr),
      .ss_cond  (calc_ss)
   );

   assign reg_fld  = modrm_q.reg_f;
   assign rm_reg   = modrm_q.rm;
   assign is_mem   = (modrm_q.mode != 2'd3);
   assign eff_addr = is_mem ? calc_addr : 32'h0;
   assign use_ss   = is_mem && calc_ss && !ovr_q;

   AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && done)); // R2
   AST_OVR_BLOCKS_SS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ovr_q) |-> !use_ss); // R9
   AST_NARROW_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_mem && !a32_q) |-> (eff_addr[31:16] == 16'h0000)); // R8
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(reg_fld) && $stable(is_mem) &&
                            $stable(rm_reg) && $stable(use_ss))); // R10

endmodule

// File: tb/sim_modrm_ea_decoder.sv
`timescale 1ns/1ps
module sim_modrm_ea_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        addr32 = 1'b0;
   logic        seg_ovr = 1'b0;
   logic [255:0] gpr_flat;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready, done, is_mem, use_ss;
   logic [2:0]  reg_fld, rm_reg;
   logic [31:0] eff_addr;

   logic [31:0] regs [8];
   int checks = 0;
   int errors = 0;
   int edges = 0;

   typedef struct {
      logic        is_mem;
      logic [2:0]  rf;
      logic [2:0]  rm;
      logic [31:0] addr;
      logic        ss;
      int          lat;
      string       tag;
   } exp_t;

   exp_t q[$];

   always #4 clk = ~clk;
   always @(posedge clk) edges++;

   always_comb begin
      for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = regs[i];
   end

   modrm_ea_decoder u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .addr32(addr32), .seg_ovr(seg_ovr),
      .gpr_flat(gpr_flat), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .done(done), .reg_fld(reg_fld), .is_mem(is_mem), .rm_reg(rm_reg),
      .eff_addr(eff_addr), .use_ss(use_ss)
   );

   function automatic logic [31:0] take(input logic [47:0] bs, input int p, input int n);
      logic [47:0] s;
      s = bs >> (p * 8);
      if (n == 1) return {{24{s[7]}}, s[7:0]};
      if (n == 2) return {{16{s[15]}}, s[15:0]};
      return s[31:0];
   endfunction

   // Reference model built from the requirements.
   function automatic exp_t model(input logic [47:0] bs, input logic a32, input logic ovr,
                                  output int n);
      exp_t e;
      logic [1:0] m;
      logic [2:0] rm;
      logic [7:0] sb;
      logic [31:0] a, iv, bv;
      int p;
      m = bs[7:6]; rm = bs[2:0];
      e.rf = bs[5:3]; e.rm = rm; e.is_mem = (m != 2'd3);
      e.addr = 0; e.ss = 0; p = 1; a = 0;
      if (m != 2'd3) begin
         if (a32) begin
            if (rm == 3'd4) begin
               sb = bs[15:8]; p = 2;
               iv = (sb[5:3] == 3'd4) ? 32'h0 : (regs[sb[5:3]] << sb[7:6]);
               if (sb[2:0] == 3'd5 && m == 2'd0) begin bv = take(bs, p, 4); p += 4; end
               else bv = regs[sb[2:0]];
               a = bv + iv; e.ss = (sb[2:0] == 3'd4);
            end else if (rm == 3'd5 && m == 2'd0) begin
               a = take(bs, p, 4); p += 4;
            end else begin
               a = regs[rm]; e.ss = (rm == 3'd5);
            end
            if (m == 2'd1) begin a += take(bs, p, 1); p += 1; end
            if (m == 2'd2) begin a += take(bs, p, 4); p += 4; end
         end else begin
            case (rm)
               3'd0: a = regs[3][15:0] + regs[6][15:0];
               3'd1: a = regs[3][15:0] + regs[7][15:0];
               3'd2: a = regs[5][15:0] + regs[6][15:0];
               3'd3: a = regs[5][15:0] + regs[7][15:0];
               3'd4: a = regs[6][15:0];
               3'd5: a = regs[7][15:0];
               3'd6: a = (m == 2'd0) ? 32'h0 : regs[5][15:0];
               default: a = regs[3][15:0];
            endcase
            if (m == 2'd0 && rm == 3'd6) begin a += take(bs, p, 2); p += 2; end
            if (m == 2'd1) begin a += take(bs, p, 1); p += 1; end
            if (m == 2'd2) begin a += take(bs, p, 2); p += 2; end
            a = a & 32'h0000_FFFF;
            e.ss = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && m != 2'd0);
         end
         e.addr = a;
         if (ovr) e.ss = 1'b0;
      end
      n = p;
      return e;
   endfunction

   task automatic run(input logic [47:0] bs, input logic a32, input logic ovr,
                      input int stall_at, input string tag);
      exp_t e;
      int n;
      e = model(bs, a32, ovr, n);
      e.lat = n + 1 + ((stall_at >= 0 && stall_at < n) ? 1 : 0);
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      addr32 = a32; seg_ovr = ovr; start = 1'b1; edges = 0;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (i == stall_at) begin in_valid = 1'b0; @(negedge clk); end
         in_valid = 1'b1; in_data = bs[i*8 +: 8];
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // Monitor / scoreboard
   logic prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (done && !prev_done) begin
            checks++;
            if (q.size() == 0) begin
               errors++;
               $display("FAIL R2: done with no pending decode, actual done=1 expected 0");
            end else begin
               exp_t e;
               e = q.pop_front();
               if (is_mem !== e.is_mem || reg_fld !== e.rf ||
                   (!e.is_mem && rm_reg !== e.rm) ||
                   (e.is_mem && eff_addr !== e.addr) || use_ss !== e.ss || edges != e.lat) begin
                  errors++;
                  $display("FAIL %s: actual mem=%0b reg=%0d rm=%0d addr=%h ss=%0b lat=%0d expected mem=%0b reg=%0d rm=%0d addr=%h ss=%0b lat=%0d",
                           e.tag, is_mem, reg_fld, rm_reg, eff_addr, use_ss, edges,
                           e.is_mem, e.rf, e.rm, e.addr, e.ss, e.lat);
               end
            end
         end
         prev_done = done;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] held;
      regs = '{32'h1000_0004, 32'h0000_0100, 32'h0000_0002, 32'hABC3_F000,
               32'h7FFF_0010, 32'hABC5_8001, 32'hABC6_2345, 32'hABC7_00FF};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (done !== 1'b0 || in_ready !== 1'b0) begin
         errors++;
         $display("FAIL R2: reset actual done=%0b ready=%0b expected 0 0", done, in_ready);
      end

      run(48'h0000_0000_00C8, 1'b1, 1'b0, -1, "R1");                 // register form
      run(48'h0000_0000_00F5, 1'b0, 1'b0, -1, "R1");
      run(48'h0000_0000_0003, 1'b1, 1'b0, -1, "R1");                 // [reg3]
      run(48'h0000_0000_FC40, 1'b1, 1'b0, -1, "R6");                 // disp8 negative
      run(48'h0012_3456_7886, 1'b1, 1'b0, -1, "R6");                 // disp32
      run(48'h0012_3456_7886, 1'b1, 1'b0, 2, "R2");                  // with bubble
      run(48'h00DE_ADBE_EF05, 1'b1, 1'b0, -1, "R5");                 // disp alone
      run(48'h0000_0000_1045, 1'b1, 1'b0, -1, "R5");                 // reg5 base, SS
      run(48'h0000_0000_1045, 1'b1, 1'b1, -1, "R9");                 // override
      run(48'h0000_0000_8B04, 1'b1, 1'b0, -1, "R3");                 // scale 4
      run(48'h0000_0000_E004, 1'b1, 1'b0, -1, "R3");                 // no index
      run(48'h0011_2233_4504, 1'b1, 1'b0, -1, "R4");                 // stream base
      run(48'h0000_0000_0544, 1'b1, 1'b0, -1, "R4");                 // base 5 mode 1
      run(48'h0000_0000_2404, 1'b1, 1'b0, -1, "R9");                 // base 4 -> SS
      run(48'h0000_0000_2404, 1'b1, 1'b1, -1, "R9");

      for (int m = 0; m < 3; m++) begin
         for (int rm = 0; rm < 8; rm++) begin
            logic [7:0] b0;
            logic [47:0] bs;
            b0 = {2'(m), 3'(7 - rm), 3'(rm)};
            if (m == 0)      bs = {24'h0, 8'h12, 8'h34, b0};
            else if (m == 1) bs = {32'h0, 8'h90, b0};
            else             bs = {24'h0, 8'h84, 8'h21, b0};
            run(bs, 1'b0, (m == 1 && rm == 2), -1, (rm[0] ? "R7" : "R8"));
         end
      end

      // R10: hold after done, ignore register changes and offered bytes
      run(48'h0012_3456_7886, 1'b1, 1'b0, -1, "R10");
      held = eff_addr;
      regs[6] = 32'h5555_5555;
      in_valid = 1'b1; in_data = 8'hC0;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      checks++;
      if (!done || eff_addr !== held || reg_fld !== 3'd0 || in_ready !== 1'b0) begin
         errors++;
         $display("FAIL R10: actual done=%0b addr=%h reg=%0d ready=%0b expected 1 %h 0 0",
                  done, eff_addr, reg_fld, in_ready, held);
      end
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R2: actual %0d decodes never completed expected 0", q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule